// File: doc/BRIEF.md
# Arm and Sync Controller for a Decade Divider Chain

This block lets an operator halt a clock divider chain and restart it so that its generated one-pulse-per-second output lines up with an external 1PPS reference. An active-low arm input, which is normally pulled high, stops the chain. Releasing arm clears the chain and presets its outputs high. The block then waits for a complete low-then-high sequence on the reference sync input, and releases the chain on that rising edge.

Both operator-side inputs are asynchronous. Each passes through a multi-flop synchronizer before any decision is made on it. The divider supplies a one-cycle base tick strobe in the clock domain. The arm level is only acted on in cycles that carry that strobe, which mirrors a divider that checks arm once per base period. The outputs are all registered: a hold level, a one-cycle clear pulse and two status indicators (red and green).

The resume latency is fixed at the synchronizer depth plus one clock. The divider therefore restarts a constant, known number of clocks after the reference edge. That offset is far below one base tick.

Top module: `arm_sync_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the block in the free-running state. In that state hold_o, clear_o, red_o and green_o are all 0. Reset is also the only way back to this state.
- R2: In the free-running state, a low synchronized arm level with tick_i high stops the divider: hold_o=1, red_o=1, green_o=0. A low arm level in cycles without tick_i has no effect.
- R3: In the stopped state, the block stays stopped (hold_o=1, red_o=1, green_o=0) for as long as synchronized arm is low, whatever tick_i and sync_i do.
- R4: When synchronized arm is high in the stopped state, the block enters the waiting state and drives clear_o high for exactly one clock, in the same cycle that green_o first goes high.
- R5: In the waiting state, hold_o stays 1 until the synchronized sync input has been seen low at least once inside that state. A sync input that is already high on entry does not release the divider.
- R6: In the waiting state, the first high synchronized sync sample after a low one moves the block to running-in-sync: hold_o=0, red_o=0, green_o=1.
- R7: With the default two synchronizer stages, a change on arm_n_i or sync_i driven between two clock edges shows at the registered outputs after the third rising edge that follows.
- R8: In the running-in-sync state, a low synchronized arm level with tick_i high stops the divider again: hold_o=1, red_o=1, green_o=0.
- R9: Activity on sync_i has no effect in the free-running, stopped and running-in-sync states.
- R10: The indicator code is fixed by state: free-running has both indicators off, stopped has red only, waiting has red and green, running-in-sync has green only. hold_o equals red_o in every state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle divider base tick strobe, clock domain |
| arm_n_i | input | 1 | Asynchronous active-low arm request, idle high |
| sync_i | input | 1 | Asynchronous 1PPS reference input |
| hold_o | output | 1 | Freezes the divider chain while 1 |
| clear_o | output | 1 | One-cycle pulse: clear counters, preset outputs high |
| red_o | output | 1 | Red status indicator |
| green_o | output | 1 | Green status indicator |

## Verification
The bench targets a sync input that is already high when waiting begins. A design that treats a high level as the edge would release at once, without waiting for the reference. It toggles arm in cycles with no tick; a block that ignores the tick would stop early. It counts the clear pulse width, since a pulse that is held would keep the divider cleared past the resume. It also times the exact edge count from the sync rise to the release of hold, because an extra or missing register would move the restarted 1PPS away from the reference.

// File: rtl/arm_sync_pkg.sv
package arm_sync_pkg;
  typedef enum logic [1:0] {
    ST_FREE  = 2'd0,
    ST_HALT  = 2'd1,
    ST_ALIGN = 2'd2,
    ST_LOCK  = 2'd3
  } ctl_state_e;

  localparam int unsigned IDX_ARM  = 0;
  localparam int unsigned IDX_SYNC = 1;
  localparam int unsigned N_ASYNC  = 2;
endpackage

// File: rtl/sync_bank.sv
module sync_bank #(
  parameter int unsigned WIDTH = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int unsigned LAST = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[b]}};
      else     chain <= {chain[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain[LAST];
  end
endmodule

// File: rtl/low_high_detect.sv
module low_high_detect (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic en_i,
  input  logic lvl_i,
  output logic primed_o,
  output logic rise_o
);
  logic primed_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i)          primed_q <= 1'b0;
    else if (en_i && !lvl_i)   primed_q <= 1'b1;
  end

  assign primed_o = primed_q;
  assign rise_o   = en_i && primed_q && lvl_i;

  // R5
  primed_after_low_chk: assert property (@(posedge clk) disable iff (rst)
    (en_i && !clr_i && !lvl_i) |=> primed_o);
endmodule

// File: rtl/arm_fsm.sv
module arm_fsm
  import arm_sync_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       arm_n_s,
  input  logic       rise_i,
  output ctl_state_e state_o,
  output logic       hold_o,
  output logic       clear_o,
  output logic       red_o,
  output logic       green_o
);
  ctl_state_e st_q, st_d;
  logic       clr_d;

  always_comb begin
    st_d  = st_q;
    clr_d = 1'b0;
    case (st_q)
      ST_FREE:  if (tick_i && !arm_n_s) st_d = ST_HALT;
      ST_HALT:  if (arm_n_s) begin st_d = ST_ALIGN; clr_d = 1'b1; end
      ST_ALIGN: if (rise_i) st_d = ST_LOCK;
      ST_LOCK:  if (tick_i && !arm_n_s) st_d = ST_HALT;
      default:  st_d = ST_FREE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_FREE;
      hold_o  <= 1'b0;
      clear_o <= 1'b0;
      red_o   <= 1'b0;
      green_o <= 1'b0;
    end else begin
      st_q    <= st_d;
      clear_o <= clr_d;
      hold_o  <= (st_d == ST_HALT) || (st_d == ST_ALIGN);
      red_o   <= (st_d == ST_HALT) || (st_d == ST_ALIGN);
      green_o <= (st_d == ST_ALIGN) || (st_d == ST_LOCK);
    end
  end

  assign state_o = st_q;

  // R4
  clear_single_chk: assert property (@(posedge clk) disable iff (rst)
    clear_o |=> !clear_o);
  // R4
  clear_with_green_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(green_o) && red_o) |-> clear_o);
  // R2
  stop_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(hold_o)) |-> ($past(tick_i) && !$past(arm_n_s)));
  // R10
  hold_red_chk: assert property (@(posedge clk) disable iff (rst)
    hold_o == red_o);
  // R1
  no_return_free_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_FREE) |=> (st_q != ST_FREE));
endmodule

// File: rtl/arm_sync_ctrl.sv
module arm_sync_ctrl
  import arm_sync_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic arm_n_i,
  input  logic sync_i,
  output logic hold_o,
  output logic clear_o,
  output logic red_o,
  output logic green_o
);
  localparam logic [N_ASYNC-1:0] IDLE_VAL = N_ASYNC'(1 << IDX_ARM);

  logic [N_ASYNC-1:0] raw, synced;
  logic               arm_n_s, sync_s;
  logic               det_primed, det_rise;
  ctl_state_e         state;

  assign raw[IDX_ARM]  = arm_n_i;
  assign raw[IDX_SYNC] = sync_i;

  sync_bank #(.WIDTH(N_ASYNC), .STAGES(SYNC_STAGES), .RST_VAL(IDLE_VAL)) u_sync (
    .clk(clk), .rst(rst), .d_i(raw), .q_o(synced)
  );

  assign arm_n_s = synced[IDX_ARM];
  assign sync_s  = synced[IDX_SYNC];

  low_high_detect u_det (
    .clk(clk), .rst(rst),
    .clr_i(state == ST_HALT), .en_i(state == ST_ALIGN), .lvl_i(sync_s),
    .primed_o(det_primed), .rise_o(det_rise)
  );

  arm_fsm u_fsm (
    .clk(clk), .rst(rst), .tick_i(tick_i), .arm_n_s(arm_n_s), .rise_i(det_rise),
    .state_o(state), .hold_o(hold_o), .clear_o(clear_o),
    .red_o(red_o), .green_o(green_o)
  );

  // R6
  hold_release_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(hold_o)) |-> ($past(det_primed) && $past(sync_s) && green_o));
  // R9
  sync_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (state != ST_ALIGN) |-> !det_rise);
endmodule

// File: tb/sim_arm_sync_ctrl.sv
module sim_arm_sync_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, arm_n = 1'b1, sync_in = 1'b0;
  logic hold, clr, red, green;
  int   n_cmp = 0, n_bad = 0, cyc = 0;
  bit   tick_en = 1'b1;
  int   tdiv = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  arm_sync_ctrl u0 (
    .clk(clk), .rst(rst), .tick_i(tick), .arm_n_i(arm_n), .sync_i(sync_in),
    .hold_o(hold), .clear_o(clr), .red_o(red), .green_o(green)
  );

  // tick strobe generator, driven away from the active edge
  always @(negedge clk) begin
    tdiv = (tdiv == 4) ? 0 : tdiv + 1;
    tick <= tick_en && (tdiv == 0);
  end

  // behavioural reference model
  int  m_st = 0;
  bit  m_seen = 0;
  bit  e_hold = 0, e_clr = 0, e_red = 0, e_green = 0;
  bit  arm_q[$], syn_q[$];

  always @(posedge clk) begin
    bit a, s;
    if (rst) begin
      m_st = 0; m_seen = 0;
      arm_q = {1'b1, 1'b1}; syn_q = {1'b0, 1'b0};
      e_clr = 0;
    end else begin
      a = arm_q.pop_front(); s = syn_q.pop_front();
      arm_q.push_back(arm_n); syn_q.push_back(sync_in);
      e_clr = 0;
      if (m_st == 0) begin
        if (tick && !a) m_st = 1;
      end else if (m_st == 1) begin
        m_seen = 0;
        if (a) begin m_st = 2; e_clr = 1; end
      end else if (m_st == 2) begin
        if (s && m_seen) m_st = 3;
        else if (!s) m_seen = 1;
      end else begin
        if (tick && !a) m_st = 1;
      end
    end
    e_hold  = (m_st == 1) || (m_st == 2);
    e_red   = e_hold;
    e_green = (m_st == 2) || (m_st == 3);
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    cyc++;
    if (cyc > 3) chk(cur_req, {hold, clr, red, green}, {e_hold, e_clr, e_red, e_green});
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 20000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int cnt;
    idle(5);
    rst <= 1'b0;
    idle(2);
    // R1 reset state
    chk("R1", {hold, clr, red, green}, 0);

    // R2 arm low without ticks does nothing
    cur_req = "R2";
    tick_en = 0; idle(2);
    arm_n <= 1'b0; idle(20);
    chk("R2", hold, 0);
    arm_n <= 1'b1; idle(4);
    tick_en = 1;
    // R2 arm low with ticks stops the divider
    arm_n <= 1'b0; idle(12);
    chk("R2", {hold, red, green}, 3'b110);
    // R10 stopped shows red only
    chk("R10", {red, green}, 2'b10);

    // R3 / R9 stay stopped while arm low, sync toggling
    cur_req = "R3";
    for (int i = 0; i < 6; i++) begin sync_in <= ~sync_in; idle(5); end
    chk("R3", {hold, red, green}, 3'b110);
    sync_in <= 1'b1; idle(4);

    // R4 release arm: one-cycle clear with green
    cur_req = "R4";
    arm_n <= 1'b1;
    cnt = 0;
    repeat (8) begin @(negedge clk); if (clr) begin cnt++; chk("R4", green, 1); end end
    chk("R4", cnt, 1);
    chk("R10", {red, green}, 2'b11);

    // R5 sync already high on entry must not resume
    cur_req = "R5";
    idle(30);
    chk("R5", hold, 1);
    sync_in <= 1'b0; idle(10);
    chk("R5", hold, 1);

    // R6 / R7 rising edge resumes after a fixed latency
    cur_req = "R6";
    sync_in <= 1'b1;
    cnt = 0;
    while (hold && cnt < 20) begin @(negedge clk); cnt++; end
    chk("R7", cnt, 3);
    chk("R6", {hold, red, green}, 3'b001);

    // R9 sync activity while locked is ignored
    cur_req = "R9";
    for (int i = 0; i < 6; i++) begin sync_in <= ~sync_in; idle(4); end
    chk("R9", {hold, red, green}, 3'b001);

    // R8 re-arm from locked, then a second alignment with sync low on entry
    cur_req = "R8";
    sync_in <= 1'b0;
    arm_n <= 1'b0; idle(12);
    chk("R8", {hold, red, green}, 3'b110);
    arm_n <= 1'b1; idle(10);
    chk("R5", hold, 1);
    cur_req = "R6";
    sync_in <= 1'b1; idle(6);
    chk("R6", {hold, red, green}, 3'b001);

    // R1 reset from locked returns to free-running
    cur_req = "R1";
    rst <= 1'b1; idle(3);
    rst <= 1'b0; idle(3);
    chk("R1", {hold, clr, red, green}, 0);
    idle(5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule